// File: doc/BRIEF.md
# Power-Switch Request Interrupt Block

This block sits between a storage-card host controller core and the software that runs the power rails. The core raises four kinds of request: bus power off, bus power on, I/O voltage low and I/O voltage high. The block latches each request in a sticky status register. It raises one level interrupt for any pending request that software has enabled. Software then reports the outcome through a control register, and the block forwards that outcome to the requester as one-cycle completion pulses, together with the value that was written.

Software reaches the block through a simple word-addressed register port. A write strobe, an address and write data act on the rising clock edge. Read data is returned combinationally for the address presented. Four word offsets are decoded, and every other offset reads as zero and ignores writes. A request that was captured while its interrupt was disabled stays pending. Software can therefore clear any leftover requests from before reset release before it enables the interrupt, so that the interrupt does not fire early.

Top module: `pwrsw_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all readable registers return 0, `irq_o` is low, both completion pulses are low and `done_data_o` is 0.
- R2: A high level on `req_i[b]` during a clock edge sets status bit b, which stays set after the request drops. Bit 0 is bus off, bit 1 bus on, bit 2 I/O low and bit 3 I/O high.
- R3: Reads decode word offsets 0 = status, 1 = interrupt enable, 2 = clear (reads 0) and 3 = control. Control reads back only bit 0 and bit 2 of the last written value. All other bits, and any other offset, read 0.
- R4: Writing offset 2 clears every status bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R5: When a request and a clear of the same status bit arrive on the same edge, the bit ends up set.
- R6: `irq_o` is high exactly when some status bit and its enable bit are both 1. A request latched while its enable bit is 0 does not raise `irq_o`, but it does raise `irq_o` once the enable bit is later written to 1.
- R7: The enable register at offset 1 stores only write-data bits 3:0. Higher bits are dropped.
- R8: A write to offset 3 with bit 0 set gives a one-cycle `bus_done_o` pulse, and with bit 2 set a one-cycle `io_done_o` pulse, in the cycle after the write. `done_data_o` then carries the full written word.
- R9: A write to offset 3 with bit 0 clear gives no `bus_done_o` pulse, and with bit 2 clear gives no `io_done_o` pulse. Bits 1 and 3 trigger nothing.
- R10: Writes to offset 0 or to any undecoded offset change neither the status nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Switch requests: bus off, bus on, I/O low, I/O high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word offset of the access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |
| bus_done_o | output | 1 | Bus power switch reported successful (one cycle) |
| io_done_o | output | 1 | I/O voltage switch reported successful (one cycle) |
| done_data_o | output | DATA_W | Last value written to the control register |

## Verification
The bench sweeps every status pattern against every clear pattern. A design that cleared bits written 0, or that let a clear beat a request arriving on the same edge, would read back a wrong status. It also crosses every enable pattern with every request pattern, and checks the case where a request waits with its interrupt disabled. A design that gated capture with the enable, or that fired the interrupt while the enable was 0, would be caught there. Every control nibble is written with junk in the upper bits. This exposes pulses that last two cycles, pulses taken from bit 1 or bit 3 instead of bits 0 and 2, and readback that leaks undefined bits. Finally, writes to the status offset and to undecoded offsets must leave the stored state unchanged.

// File: rtl/pwrsw_pkg.sv
// Package: shared constants and types for the power-switch request block.
// Assumes word-granular register offsets; bit meanings are fixed by the requester.
package pwrsw_pkg;
    localparam int NUM_REQ     = 4;
    localparam int REQ_BUS_OFF = 0;
    localparam int REQ_BUS_ON  = 1;
    localparam int REQ_IO_LOW  = 2;
    localparam int REQ_IO_HIGH = 3;

    // Word offsets, in decode order.
    localparam int OFS_STAT = 0;
    localparam int OFS_EN   = 1;
    localparam int OFS_CLR  = 2;
    localparam int OFS_CTL  = 3;

    // Success-report bit positions in the control register.
    localparam int CTL_BUS_OK = 0;
    localparam int CTL_IO_OK  = 2;

    typedef struct packed {
        logic stat;
        logic en;
        logic clr;
        logic ctl;
    } reg_hit_t;
endpackage

// File: rtl/pwrsw_regdec.sv
// Module: address decoder. Turns a word offset into one-hot register hits.
// Assumes offsets come from pwrsw_pkg; undecoded offsets give no hit.
module pwrsw_regdec
    import pwrsw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_hit_t          hit_o
);
    // Compare the offset against each decoded register.
    always_comb begin
        hit_o      = '0;
        hit_o.stat = (addr_i == ADDR_W'(OFS_STAT));
        hit_o.en   = (addr_i == ADDR_W'(OFS_EN));
        hit_o.clr  = (addr_i == ADDR_W'(OFS_CLR));
        hit_o.ctl  = (addr_i == ADDR_W'(OFS_CTL));
    end
endmodule

// File: rtl/pwrsw_status.sv
// Module: sticky request status with write-one-to-clear.
// Assumes requests are sampled each edge; a request beats a clear of the same bit.
module pwrsw_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_bits_i,
    output logic [N-1:0] status_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic bit_q;
        // Hold one request bit until software clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (req_i[b])
                bit_q <= 1'b1;
            else if (clr_en_i && clr_bits_i[b])
                bit_q <= 1'b0;
        end
        assign status_o[b] = bit_q;
    end
endmodule

// File: rtl/pwrsw_ack.sv
// Module: control register and completion pulse generator.
// Assumes one success bit covers both directions of a switch (on/off, low/high).
module pwrsw_ack
    import pwrsw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic              bus_done_o,
    output logic              io_done_o
);
    logic [DATA_W-1:0] ctl_q;
    logic              bus_q;
    logic              io_q;

    // Keep the last written control word for the requester and readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en_i)
            ctl_q <= wdata_i;
    end

    // Turn each set success bit into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= 1'b0;
            io_q  <= 1'b0;
        end else begin
            bus_q <= wr_en_i && wdata_i[CTL_BUS_OK];
            io_q  <= wr_en_i && wdata_i[CTL_IO_OK];
        end
    end

    assign ctl_o      = ctl_q;
    assign bus_done_o = bus_q;
    assign io_done_o  = io_q;
endmodule

// File: rtl/pwrsw_irq_ctrl.sv
// Module: top of the power-switch request interrupt block.
// Latches requests, masks them into one level interrupt, and forwards
// software's success report as completion pulses. Assumes DATA_W >= 4.
module pwrsw_irq_ctrl
    import pwrsw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        req_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              bus_done_o,
    output logic              io_done_o,
    output logic [DATA_W-1:0] done_data_o
);
    localparam logic [DATA_W-1:0] CTL_RD_MASK =
        (DATA_W'(1) << CTL_BUS_OK) | (DATA_W'(1) << CTL_IO_OK);

    reg_hit_t            hit;
    logic [NUM_REQ-1:0]  status_q;
    logic [NUM_REQ-1:0]  mask_q;
    logic [DATA_W-1:0]   ctl_q;

    pwrsw_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (reg_addr_i),
        .hit_o  (hit)
    );

    pwrsw_status #(.N(NUM_REQ)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .clr_en_i   (reg_we_i && hit.clr),
        .clr_bits_i (reg_wdata_i[NUM_REQ-1:0]),
        .status_o   (status_q)
    );

    pwrsw_ack #(.DATA_W(DATA_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_we_i && hit.ctl),
        .wdata_i    (reg_wdata_i),
        .ctl_o      (ctl_q),
        .bus_done_o (bus_done_o),
        .io_done_o  (io_done_o)
    );

    // Interrupt enable register, low request bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_we_i && hit.en)
            mask_q <= reg_wdata_i[NUM_REQ-1:0];
    end

    // Read multiplexer; undecoded offsets and bits return zero.
    always_comb begin
        reg_rdata_o = '0;
        if (hit.stat)
            reg_rdata_o = DATA_W'(status_q);
        else if (hit.en)
            reg_rdata_o = DATA_W'(mask_q);
        else if (hit.ctl)
            reg_rdata_o = ctl_q & CTL_RD_MASK;
    end

    // Level interrupt from enabled pending requests.
    assign irq_o       = |(status_q & mask_q);
    assign done_data_o = ctl_q;
endmodule

// File: rtl/pwrsw_irq_ctrl_chk.sv
// Module: property checker for pwrsw_irq_ctrl, attached by bind.
module pwrsw_irq_ctrl_chk
    import pwrsw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        req_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [3:0]        wdata_lo,
    input logic [3:0]        status_q,
    input logic              irq_o,
    input logic              bus_done_o,
    input logic              io_done_o
);
    logic wr_clr, wr_ctl, wr_en;
    assign wr_clr = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CLR));
    assign wr_ctl = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CTL));
    assign wr_en  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_EN));

    // R2 and R5: a request always lands in status, clear or not.
    assert_req_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> ((status_q & $past(req_i)) == $past(req_i)));

    // R4: cleared bits without a competing request drop.
    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((status_q & $past(wdata_lo) & ~$past(req_i)) == 4'h0));

    // R10: without a clear write no status bit ever drops.
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8: success bits produce their pulses.
    assert_bus_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata_lo[CTL_BUS_OK]) |=> bus_done_o);
    assert_io_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata_lo[CTL_IO_OK]) |=> io_done_o);

    // R9: no pulse without a control write carrying the bit.
    assert_bus_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done_o |-> $past(wr_ctl && wdata_lo[CTL_BUS_OK]));
    assert_io_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_done_o |-> $past(wr_ctl && wdata_lo[CTL_IO_OK]));

    // R6: the interrupt rises only after a request or an enable write.
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(|req_i) || $past(wr_en)));
endmodule

bind pwrsw_irq_ctrl pwrsw_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .wdata_lo   (reg_wdata_i[3:0]),
    .status_q   (status_q),
    .irq_o      (irq_o),
    .bus_done_o (bus_done_o),
    .io_done_o  (io_done_o)
);

// File: tb/pwrsw_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pwrsw_irq_ctrl_bench;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    req = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, bus_done, io_done;
    logic [DW-1:0] done_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pwrsw_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_pwrsw_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .bus_done_o  (bus_done),
        .io_done_o   (io_done),
        .done_data_o (done_data)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] r);
        we = 1'b1; addr = a; wdata = d; req = r;
        @(negedge clk);
        we = 1'b0; addr = '0; wdata = '0; req = '0;
    endtask

    task automatic pulse(input logic [3:0] r);
        req = r;
        @(negedge clk);
        req = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
        addr = '0;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(AW'(a), v);
            check("R1 reg after reset", v, '0);
        end
        check("R1 irq", DW'(irq), '0);
        check("R1 bus_done", DW'(bus_done), '0);
        check("R1 io_done", DW'(io_done), '0);
        check("R1 done_data", done_data, '0);

        // R6: request waits while disabled, fires once enabled
        pulse(4'b1000);
        check("R6 irq while disabled", DW'(irq), '0);
        rd(0, v);
        check("R2 pending io-high", v, 32'h8);
        wr(1, 32'hF, 4'h0);
        check("R6 irq after enable", DW'(irq), 32'h1);
        wr(2, 32'hF, 4'h0);
        check("R6 irq after clear", DW'(irq), '0);
        wr(1, 32'h0, 4'h0);

        // R4 and R5: every status pattern against every clear pattern
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                wr(2, 32'hF, 4'h0);
                pulse(4'(s));
                rd(0, v);
                check("R2 status latched", v, DW'(s));
                wr(2, DW'(c), 4'h0);
                rd(0, v);
                check("R4 clear result", v, DW'(s & ~c & 15));
                wr(2, 32'hF, 4'(c));
                rd(0, v);
                check("R5 request beats clear", v, DW'(c));
            end
        end

        // R6 and R7: every enable pattern against every request pattern
        for (int m = 0; m < 16; m++) begin
            wr(1, 32'hFFFF_FFF0 | DW'(m), 4'h0);
            rd(1, v);
            check("R7 enable readback", v, DW'(m));
            for (int s = 0; s < 16; s++) begin
                wr(2, 32'hF, 4'h0);
                pulse(4'(s));
                check("R6 irq level", DW'(irq), DW'((s & m) != 0));
            end
        end

        // R8, R9, R3: every control nibble with junk in the upper bits
        for (int k = 0; k < 16; k++) begin
            wr(3, 32'hA5A5_A5A0 | DW'(k), 4'h0);
            check("R8 bus_done pulse", DW'(bus_done), DW'(k & 1));
            check("R9 io_done pulse", DW'(io_done), DW'((k >> 2) & 1));
            check("R8 done_data", done_data, 32'hA5A5_A5A0 | DW'(k));
            @(negedge clk);
            check("R8 bus_done one cycle", DW'(bus_done), '0);
            check("R8 io_done one cycle", DW'(io_done), '0);
            rd(3, v);
            check("R3 control readback", v, DW'(k & 5));
            rd(2, v);
            check("R3 clear reads zero", v, '0);
        end

        // R10 and R3: status offset and undecoded offsets ignore writes
        wr(2, 32'hF, 4'h0);
        wr(1, 32'h5, 4'h0);
        pulse(4'b0110);
        wr(0, 32'hFFFF_FFFF, 4'h0);
        for (int a = 4; a < 16; a++) begin
            wr(AW'(a), 32'hFFFF_FFFF, 4'h0);
            rd(AW'(a), v);
            check("R3 undecoded read", v, '0);
        end
        rd(0, v);
        check("R10 status unchanged", v, 32'h6);
        rd(1, v);
        check("R10 enable unchanged", v, 32'h5);
        check("R10 no pulse", DW'(bus_done | io_done), '0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule